// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Transmitter

This block turns a stream of bytes into the symbol sequence of a single-wire variable-pulse-width bus. It has no bit clock: the line changes level after every symbol, and each symbol's length depends on the bit value and on the level the line holds while it is sent. All durations are counted in pulses of a one-microsecond tick input, so the system clock only has to be faster than the tick.

A frame starts when a byte is offered while the transmitter is idle. The block drives an active start symbol, then the bits of each byte with the most significant bit first, then a passive end-of-data period. After that the line stays passive until the inter-frame gap has run out, and only then does the block take a new frame. Bytes are supplied over a valid/ready handshake with a marker on the final byte. The next byte of a frame is taken in the single cycle in which the eighth bit of the current byte ends. If no byte is offered at that moment, or if a break is requested, the block sends a break: an edge from passive to active, a long active period, and then a full inter-frame gap.

Top module: `vpw_tx`

## Requirements
- R1: During and right after reset, `bus_out` is 0 (passive, where 1 means active) and `in_ready` is 1.
- R2: When a byte is accepted in idle, `bus_out` goes to 1 on the next clock and stays there for 200 ticks. This is the start symbol.
- R3: Data bits follow the start symbol with the most significant bit first. The line level inverts at every symbol boundary, so the first bit of every byte is passive.
- R4: A 0 bit lasts 64 ticks when it is sent passive and 128 ticks when it is sent active.
- R5: A 1 bit lasts 128 ticks when it is sent passive and 64 ticks when it is sent active.
- R6: After the last bit of a byte marked last, the line is passive for 200 ticks (end of data) and then for another 100 ticks. `in_ready` rises in the cycle after the 300th passive tick and not before.
- R7: In idle, `in_ready` is high unless a break is requested. Inside a frame it is high only in the cycle in which the final tick of the eighth bit of a byte not marked last arrives. A byte taken in that cycle starts its first bit on the next clock, with no gap.
- R8: If `in_valid` is low in the cycle where R7 raises `in_ready` inside a frame, a break follows. The line is driven passive for 64 ticks, then active for 300 ticks, then passive for 300 ticks before `in_ready` returns.
- R9: A `brk_req` seen in idle, during the start symbol, during a data bit or during end of data aborts that symbol at once and sends a break. If the line is active at that moment, a 64-tick passive lead-in comes first. The break is 300 active ticks followed by a 300-tick passive gap.
- R10: `brk_req` has no effect during the lead-in, the break itself or the passive gap that follows it. The active period stays at exactly 300 ticks and the gap at 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken in this cycle if valid |
| in_data | input | 8 | Byte to send, most significant bit first |
| in_last | input | 1 | Offered byte closes the frame |
| brk_req | input | 1 | Request to abort and send a break |
| bus_out | output | 1 | Line level, 1 = active |

## Verification
The assertions assume that `us_tick` is a one-cycle pulse with at least one idle cycle between pulses. They also assume that an offered byte stays on `in_data` and `in_last` until it is taken. The stimulus produces a tick every third clock and changes inputs just after a rising edge. It keeps each byte steady until the handshake and only lowers `in_valid` on purpose, to provoke the break of R8. Random frames mix lengths, data and deliberate underruns, and directed cases cover all-zero and all-one bytes, breaks from idle and from inside the start symbol, and break requests repeated during a break.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_BIT,
    ST_EOD,
    ST_IFS,
    ST_LEAD,
    ST_BRK
  } tx_state_e;

  // A symbol is long when the bit value differs from "sent active".
  function automatic int unsigned bit_span(input logic bval, input logic lvl_active,
                                           input int unsigned short_us,
                                           input int unsigned long_us);
    return (bval ^ lvl_active) ? long_us : short_us;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vpw_span_timer.sv
module vpw_span_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= '0;
    else if (load)                 remain <= load_val;
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  // The symbol ends on the tick that uses up the last microsecond.
  assign expire = tick && (remain == CNT_W'(1));
endmodule

// File: rtl/vpw_bit_shifter.sv
module vpw_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         last_in,
  input  logic         adv,
  output logic         cur_bit,
  output logic         nxt_bit,
  output logic         final_bit,
  output logic         last_q
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      idx    <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh     <= data;
      idx    <= '0;
      last_q <= last_in;
    end else if (adv) begin
      sh     <= {sh[W-2:0], 1'b0};
      idx    <= idx + 1'b1;
    end
  end

  assign cur_bit   = sh[W-1];
  assign nxt_bit   = sh[W-2];
  assign final_bit = (idx == IW'(W-1));
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_tx_pkg::*;
#(
  parameter int W        = 8,
  parameter int US_SHORT = 64,
  parameter int US_LONG  = 128,
  parameter int US_SOF   = 200,
  parameter int US_EOD   = 200,
  parameter int US_IFS   = 300,
  parameter int US_BRK   = 300
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         us_tick,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  input  logic         brk_req,
  output logic         bus_out
);
  localparam int unsigned MAX_US = max_of(max_of(max_of(US_LONG, US_SOF), US_IFS),
                                          max_of(US_BRK, US_EOD));
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam int IFS_REM = US_IFS - US_EOD;

  tx_state_e        st, st_d;
  logic             bus_q, bus_d;
  logic             tm_load;
  logic [CNT_W-1:0] tm_val;
  logic             sh_adv;
  logic             cur_bit, nxt_bit, final_bit, last_q;

  // Named events, also observed by the checker.
  logic sym_end, byte_end, need_next, brk_honor, brk_go, accept;

  function automatic logic [CNT_W-1:0] span(input logic b, input logic lvl);
    return CNT_W'(bit_span(b, lvl, US_SHORT, US_LONG));
  endfunction

  vpw_span_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(us_tick),
    .load(tm_load), .load_val(tm_val), .expire(sym_end)
  );

  vpw_bit_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .data(in_data), .last_in(in_last),
    .adv(sh_adv), .cur_bit(cur_bit), .nxt_bit(nxt_bit),
    .final_bit(final_bit), .last_q(last_q)
  );

  assign byte_end  = (st == ST_BIT) && sym_end && final_bit;
  assign need_next = byte_end && !last_q;
  assign brk_honor = brk_req && (st == ST_IDLE || st == ST_SOF ||
                                 st == ST_BIT  || st == ST_EOD);
  assign in_ready  = !brk_req && ((st == ST_IDLE) || need_next);
  assign accept    = in_valid && in_ready;
  assign brk_go    = brk_honor || (need_next && !in_valid);

  always_comb begin
    st_d    = st;
    bus_d   = bus_q;
    tm_load = 1'b0;
    tm_val  = '0;
    sh_adv  = 1'b0;
    if (brk_go) begin
      tm_load = 1'b1;
      if (bus_q) begin
        st_d   = ST_LEAD;
        bus_d  = 1'b0;
        tm_val = CNT_W'(US_SHORT);
      end else begin
        st_d   = ST_BRK;
        bus_d  = 1'b1;
        tm_val = CNT_W'(US_BRK);
      end
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st_d    = ST_SOF;
          bus_d   = 1'b1;
          tm_load = 1'b1;
          tm_val  = CNT_W'(US_SOF);
        end
        ST_SOF: if (sym_end) begin
          st_d    = ST_BIT;
          bus_d   = 1'b0;
          tm_load = 1'b1;
          tm_val  = span(cur_bit, 1'b0);
        end
        ST_BIT: if (sym_end) begin
          tm_load = 1'b1;
          if (!final_bit) begin
            sh_adv = 1'b1;
            bus_d  = !bus_q;
            tm_val = span(nxt_bit, !bus_q);
          end else if (last_q) begin
            st_d   = ST_EOD;
            bus_d  = 1'b0;
            tm_val = CNT_W'(US_EOD);
          end else begin
            bus_d  = 1'b0;
            tm_val = span(in_data[W-1], 1'b0);
          end
        end
        ST_EOD: if (sym_end) begin
          st_d    = ST_IFS;
          tm_load = 1'b1;
          tm_val  = CNT_W'(IFS_REM);
        end
        ST_IFS: if (sym_end) st_d = ST_IDLE;
        ST_LEAD: if (sym_end) begin
          st_d    = ST_BRK;
          bus_d   = 1'b1;
          tm_load = 1'b1;
          tm_val  = CNT_W'(US_BRK);
        end
        ST_BRK: if (sym_end) begin
          st_d    = ST_IFS;
          bus_d   = 1'b0;
          tm_load = 1'b1;
          tm_val  = CNT_W'(US_IFS);
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      bus_q <= 1'b0;
    end else begin
      st    <= st_d;
      bus_q <= bus_d;
    end
  end

  assign bus_out = bus_q;
endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk
  import vpw_tx_pkg::*;
#(
  parameter int US_IFS = 300
) (
  input logic      clk,
  input logic      rst_n,
  input logic      us_tick,
  input logic      in_valid,
  input logic      in_ready,
  input logic      brk_req,
  input logic      bus_out,
  input tx_state_e st,
  input logic      sym_end,
  input logic      byte_end,
  input logic      brk_go
);
  logic [15:0] pass_cnt, act_cnt;
  logic        seen_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_cnt    <= '0;
      act_cnt     <= '0;
      seen_active <= 1'b0;
    end else begin
      if (bus_out) pass_cnt <= '0;
      else if (us_tick && pass_cnt != 16'hffff) pass_cnt <= pass_cnt + 1'b1;
      if (!bus_out) act_cnt <= '0;
      else if (us_tick && act_cnt != 16'hffff) act_cnt <= act_cnt + 1'b1;
      if (bus_out) seen_active <= 1'b1;
    end
  end

  a_r3_edge_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out != $past(bus_out)) |-> $past(sym_end || brk_go || (in_valid && in_ready)));

  a_r7_ready_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (st == ST_IDLE || byte_end));

  a_r2_sof_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && in_valid && in_ready) |=> bus_out);

  a_r6_ifs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && in_valid && in_ready && seen_active) |-> (pass_cnt >= 16'(US_IFS)));

  a_r8_brk_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK && $past(st) != ST_BRK) |-> (bus_out && !$past(bus_out)));

  a_r9_brk_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_out) && $past(st) == ST_BRK) |-> (act_cnt >= 16'd240));

  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !sym_end && (st == ST_BRK || st == ST_IFS || st == ST_LEAD)) |=> (st == $past(st)));
endmodule

bind vpw_tx vpw_tx_chk #(.US_IFS(US_IFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .in_valid(in_valid),
  .in_ready(in_ready), .brk_req(brk_req), .bus_out(bus_out), .st(st),
  .sym_end(sym_end), .byte_end(byte_end), .brk_go(brk_go)
);

// File: tb/sim_vpw_tx.sv
module sim_vpw_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic brk_req = 1'b0;
  logic in_ready, bus_out;

  always #5 clk = !clk;

  vpw_tx u0 (.clk(clk), .rst_n(rst_n), .us_tick(us_tick), .in_valid(in_valid),
             .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
             .brk_req(brk_req), .bus_out(bus_out));

  int n_chk = 0, n_bad = 0;

  // Tick every third clock, changed just after the rising edge.
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk); #1;
      us_tick = (ph == 2);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected and observed runs of constant line level.
  int    exp_lvl [0:1023];
  int    exp_len [0:1023];
  bit    exp_min [0:1023];
  string exp_tag [0:1023];
  int    exp_n = 0;
  int    obs_lvl [0:1023];
  int    obs_len [0:1023];
  int    obs_n = 0;
  int    cur_lvl = 0, cur_cnt = 0;
  bit    rdy_prev = 1'b1;
  bit    first_gap = 1'b1;

  function automatic int bit_len(input int b, input int lvl);
    if (lvl == 0) return (b != 0) ? 128 : 64;
    return (b != 0) ? 64 : 128;
  endfunction

  task automatic push(input int lvl, input int len, input bit is_min, input string tag);
    exp_lvl[exp_n] = lvl;
    exp_len[exp_n] = len;
    exp_min[exp_n] = is_min;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic push_gap(input string tag);
    push(0, first_gap ? 0 : 300, 1'b1, tag);
    first_gap = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(bus_out) == cur_lvl) cur_cnt += int'(us_tick);
      else begin
        if (obs_n < 1024) begin
          obs_lvl[obs_n] = cur_lvl;
          obs_len[obs_n] = cur_cnt;
          obs_n++;
        end
        cur_lvl = int'(bus_out);
        cur_cnt = int'(us_tick);
      end
      if (in_ready && !rdy_prev && !bus_out)
        check(cur_cnt == 300, "R6", "passive ticks before ready", cur_cnt, 300);
      rdy_prev = in_ready;
    end
  end

  logic [7:0] fr [0:7];

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    do @(negedge clk); while (!(in_ready && !bus_out));
    @(posedge clk); #1;
  endtask

  task automatic send_frame(input int n, input bit drop);
    int lvl;
    push_gap("R6");
    push(1, 200, 1'b0, "R2");
    for (int i = 0; i < n; i++) begin
      lvl = 0;
      for (int b = 7; b >= 0; b--) begin
        push(lvl, bit_len(fr[i][b], lvl), 1'b0, fr[i][b] ? "R5" : "R4");
        lvl ^= 1;
      end
    end
    if (drop) begin
      push(0, 64, 1'b0, "R8");
      push(1, 300, 1'b0, "R8");
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == n - 1) && !drop;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    wait_idle();
  endtask

  task automatic pulse_brk();
    brk_req = 1'b1;
    @(posedge clk); #1;
    brk_req = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    bit dr;
    void'($urandom(32'd1729));
    repeat (3) @(posedge clk);
    #1;
    check(bus_out == 1'b0, "R1", "bus in reset", int'(bus_out), 0);
    check(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    check(bus_out == 1'b0, "R1", "bus after reset", int'(bus_out), 0);
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    // Directed: all zeros, all ones, a two-byte frame (R3, R7).
    fr[0] = 8'h00; send_frame(1, 1'b0);
    fr[0] = 8'hFF; send_frame(1, 1'b0);
    fr[0] = 8'hA5; fr[1] = 8'h3C; send_frame(2, 1'b0);
    // Underrun inside a frame (R8).
    fr[0] = 8'h81; send_frame(1, 1'b1);

    // Break from idle (R9).
    push_gap("R9");
    push(1, 300, 1'b0, "R9");
    pulse_brk();
    wait_idle();

    // Break during the start symbol, then requests during the break (R9, R10).
    push_gap("R9");
    push(1, 1, 1'b1, "R9");
    push(0, 64, 1'b0, "R9");
    push(1, 300, 1'b0, "R10");
    in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (150) @(posedge clk);
    #1;
    pulse_brk();
    repeat (60) @(posedge clk);
    #1;
    pulse_brk();
    do @(negedge clk); while (!bus_out);
    repeat (300) @(posedge clk);
    #1;
    pulse_brk();
    do @(negedge clk); while (bus_out);
    repeat (150) @(posedge clk);
    #1;
    pulse_brk();
    exp_tag[exp_n] = "R10";
    wait_idle();

    // Random frames.
    for (int k = 0; k < 6; k++) begin
      n  = 1 + int'($urandom % 3);
      dr = ($urandom % 4) == 0;
      for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
      send_frame(n, dr);
    end
    fr[0] = 8'h00; fr[1] = 8'hFF; fr[2] = 8'h6E; send_frame(3, 1'b0);

    repeat (1300) @(posedge clk);
    @(negedge clk);
    check(cur_lvl == 0, "R6", "final line level", cur_lvl, 0);
    check(cur_cnt >= 300, "R6", "final passive ticks", cur_cnt, 300);

    check(obs_n == exp_n, "R3", "run count", obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      if (obs_lvl[i] != exp_lvl[i])
        check(1'b0, "R3", $sformatf("level of run %0d", i), obs_lvl[i], exp_lvl[i]);
      else if (exp_min[i])
        check(obs_len[i] >= exp_len[i], exp_tag[i], $sformatf("min length run %0d", i),
              obs_len[i], exp_len[i]);
      else
        check(obs_len[i] == exp_len[i], exp_tag[i], $sformatf("length run %0d", i),
              obs_len[i], exp_len[i]);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule